// File: doc/BRIEF.md
# Stop-Mode Wake-Up Warm-Up Controller

This block sequences entry into and exit from a deep low-power state in which both oscillators are switched off. While running, software loads a restart configuration: a two-bit warm-up length code, enable bits for the fast and the slow oscillator, and a bit that picks which oscillator drives the system clock. A halt request then gates the system clock and drops both oscillator enables. The block then waits in the dark state for a wake-up interrupt.

When the interrupt arrives, the block turns the oscillators back on as the stored configuration asks. It always turns on the one picked as clock source. It then counts a power-of-two number of ticks of that source oscillator so that the oscillator can settle. After the last tick it releases the system clock from the chosen source and emits a one-cycle resume pulse for the processor. Oscillator ticks arrive as clock enables, so a stopped oscillator simply produces no ticks.

Top module: `stopwake_ctrl`

## Requirements
- R1: After reset the block is running: sys_clk_en=1, sys_clk_src=0 (fast source), osc_hi_on=1, osc_lo_on=0, resume_pulse=0.
- R2: A halt_req sampled while running makes sys_clk_en, osc_hi_on and osc_lo_on all 0 from the next cycle on.
- R3: In the stopped state the clock stays gated and both oscillator enables stay 0 for as long as no wake_irq arrives.
- R4: After wake_irq is sampled in the stopped state, sys_clk_en returns to 1 immediately after exactly N rising clock edges at which the restart oscillator's tick was high. N depends on the length code: 2'b01 gives 256, 2'b10 gives 16384, 2'b11 gives 65536, and the reserved code 2'b00 also gives 256.
- R5: During warm-up sys_clk_en is 0, the restart oscillator (fast if the source bit is 0, slow if it is 1) is enabled, and the other oscillator is enabled only if its enable bit is set.
- R6: After release, sys_clk_src equals the source bit stored before the halt (0 fast, 1 slow). osc_hi_on equals hi_en OR (source==0), and osc_lo_on equals lo_en OR (source==1).
- R7: Configuration writes are accepted only while running. A write made while stopped or warming up changes neither the warm-up length nor the settings used after release.
- R8: A wake_irq while running has no effect: the clock stays on and no resume pulse appears.
- R9: A second wake_irq during warm-up does not restart the count. Release still follows N ticks counted from the first wake-up.
- R10: resume_pulse is high for exactly one cycle, the same cycle in which sys_clk_en rises, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the restart configuration |
| cfg_wu_sel | input | 2 | Warm-up length code |
| cfg_hi_en | input | 1 | Fast oscillator enable |
| cfg_lo_en | input | 1 | Slow oscillator enable |
| cfg_clk_sel | input | 1 | System clock source, 0 fast, 1 slow |
| halt_req | input | 1 | Request to enter the stopped state |
| wake_irq | input | 1 | Wake-up interrupt |
| hi_osc_tick | input | 1 | Tick enable from the fast oscillator |
| lo_osc_tick | input | 1 | Tick enable from the slow oscillator |
| sys_clk_en | output | 1 | System clock gate, 1 = clock runs |
| sys_clk_src | output | 1 | Selected clock source |
| osc_hi_on | output | 1 | Fast oscillator run enable |
| osc_lo_on | output | 1 | Slow oscillator run enable |
| resume_pulse | output | 1 | One-cycle pulse on release |

## Verification
The bench measures the warm-up length in source ticks for every length code, including the reserved one. It uses the slow source with ticks on one cycle in four and the fast source with a gapped tick pattern. A controller that counted control-clock cycles instead of source ticks, or that was off by one tick at either end, would release early or late and fail the count comparison. The bench writes a conflicting configuration while stopped and fires a second wake-up mid-count. A design that let the late write through would release on the wrong source or after the wrong length, and one that restarted on the second interrupt would overshoot the count. A wake-up while running must leave the clock on and produce no pulse, so a design that entered warm-up from the running state would be caught.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_STOP = 2'd1,
      PS_WARM = 2'd2
   } pstate_e;

   typedef struct packed {
      logic [1:0] wu_sel;
      logic       hi_en;
      logic       lo_en;
      logic       clk_sel;
   } wake_cfg_t;

   localparam int CFG_W = $bits(wake_cfg_t);

endpackage

// File: rtl/stopwake_cfg.sv
module stopwake_cfg
   import stopwake_pkg::*;
#(
   parameter logic [1:0] RST_WU_SEL = 2'b01,
   parameter bit         RST_HI_EN  = 1'b1,
   parameter bit         RST_LO_EN  = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  wake_cfg_t wr_data,
   input  pstate_e   state_q,
   output wake_cfg_t cfg_q
);

   localparam wake_cfg_t CFG_RST = '{
      wu_sel:  RST_WU_SEL,
      hi_en:   RST_HI_EN,
      lo_en:   RST_LO_EN,
      clk_sel: 1'b0
   };

   // Writes are only taken in the running state, so the values seen at
   // the halt edge are the ones that govern the whole restart.
   logic accept;
   assign accept = wr_en && (state_q == PS_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RST;
      else if (accept)
         cfg_q <= wr_data;
   end

endmodule

// File: rtl/stopwake_fsm.sv
module stopwake_fsm
   import stopwake_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    halt_req,
   input  logic    wake_irq,
   input  logic    warm_done,
   output pstate_e state_q,
   output logic    cnt_load,
   output logic    cnt_run,
   output logic    resume_pulse
);

   pstate_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_RUN:  if (halt_req)  state_d = PS_STOP;
         PS_STOP: if (wake_irq)  state_d = PS_WARM;
         PS_WARM: if (warm_done) state_d = PS_RUN;
         default:                state_d = PS_RUN;
      endcase
   end

   assign cnt_load = (state_q == PS_STOP) && wake_irq;
   assign cnt_run  = (state_q == PS_WARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= PS_RUN;
         resume_pulse <= 1'b0;
      end else begin
         state_q      <= state_d;
         resume_pulse <= (state_q == PS_WARM) && warm_done;
      end
   end

endmodule

// File: rtl/stopwake_timer.sv
module stopwake_timer #(
   parameter int EXP_SHORT = 8,
   parameter int EXP_MID   = 14,
   parameter int EXP_LONG  = 16,
   parameter bit COUNT_DOWN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] len_code,
   output logic       done
);

   localparam int CNT_W = EXP_LONG;
   localparam logic [CNT_W-1:0] ONES   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] LIM_S  = ONES >> (CNT_W - EXP_SHORT);
   localparam logic [CNT_W-1:0] LIM_M  = ONES >> (CNT_W - EXP_MID);
   localparam logic [CNT_W-1:0] LIM_L  = ONES;

   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;
   logic             step;

   // Reserved code 2'b00 falls back to the shortest length.
   always_comb begin
      unique case (len_code)
         2'b10:   lim = LIM_M;
         2'b11:   lim = LIM_L;
         default: lim = LIM_S;
      endcase
   end

   assign step = run && tick;
   assign done = step && at_end;

   generate
      if (COUNT_DOWN) begin : g_down
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= lim;
            else if (step && !at_end)
               cnt_q <= cnt_q - 1'b1;
         end
         assign at_end = (cnt_q == '0);
      end else begin : g_up
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load)
               cnt_q <= '0;
            else if (step && !at_end)
               cnt_q <= cnt_q + 1'b1;
         end
         assign at_end = (cnt_q == lim);
      end
   endgenerate

endmodule

// File: rtl/stopwake_clkout.sv
module stopwake_clkout
   import stopwake_pkg::*;
(
   input  pstate_e   state_q,
   input  wake_cfg_t cfg_q,
   input  logic      hi_osc_tick,
   input  logic      lo_osc_tick,
   output logic      src_tick,
   output logic      sys_clk_en,
   output logic      sys_clk_src,
   output logic      osc_hi_on,
   output logic      osc_lo_on
);

   logic dark;
   assign dark = (state_q == PS_STOP);

   assign sys_clk_en  = (state_q == PS_RUN);
   assign sys_clk_src = cfg_q.clk_sel;

   // The chosen source oscillator is always kept alive outside the
   // stopped state; the other follows its own enable bit.
   assign osc_hi_on = !dark && (cfg_q.hi_en || !cfg_q.clk_sel);
   assign osc_lo_on = !dark && (cfg_q.lo_en ||  cfg_q.clk_sel);

   assign src_tick = cfg_q.clk_sel ? lo_osc_tick : hi_osc_tick;

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
   import stopwake_pkg::*;
#(
   parameter int         EXP_SHORT  = 8,
   parameter int         EXP_MID    = 14,
   parameter int         EXP_LONG   = 16,
   parameter bit         COUNT_DOWN = 1'b1,
   parameter logic [1:0] RST_WU_SEL = 2'b01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] cfg_wu_sel,
   input  logic       cfg_hi_en,
   input  logic       cfg_lo_en,
   input  logic       cfg_clk_sel,
   input  logic       halt_req,
   input  logic       wake_irq,
   input  logic       hi_osc_tick,
   input  logic       lo_osc_tick,
   output logic       sys_clk_en,
   output logic       sys_clk_src,
   output logic       osc_hi_on,
   output logic       osc_lo_on,
   output logic       resume_pulse
);

   generate
      if (!(EXP_SHORT > 0 && EXP_SHORT < EXP_MID && EXP_MID < EXP_LONG && EXP_LONG <= 30))
      begin : g_bad_exp
         $error("stopwake_ctrl: warm-up exponents must rise strictly within 1..30");
      end
   endgenerate

   wake_cfg_t wr_data;
   wake_cfg_t cfg_q;
   pstate_e   state_q;
   logic      cnt_load;
   logic      cnt_run;
   logic      warm_done;
   logic      src_tick;

   assign wr_data.wu_sel  = cfg_wu_sel;
   assign wr_data.hi_en   = cfg_hi_en;
   assign wr_data.lo_en   = cfg_lo_en;
   assign wr_data.clk_sel = cfg_clk_sel;

   stopwake_cfg #(
      .RST_WU_SEL (RST_WU_SEL),
      .RST_HI_EN  (1'b1),
      .RST_LO_EN  (1'b0)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (wr_data),
      .state_q (state_q),
      .cfg_q   (cfg_q)
   );

   stopwake_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_req     (halt_req),
      .wake_irq     (wake_irq),
      .warm_done    (warm_done),
      .state_q      (state_q),
      .cnt_load     (cnt_load),
      .cnt_run      (cnt_run),
      .resume_pulse (resume_pulse)
   );

   stopwake_timer #(
      .EXP_SHORT  (EXP_SHORT),
      .EXP_MID    (EXP_MID),
      .EXP_LONG   (EXP_LONG),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .run      (cnt_run),
      .tick     (src_tick),
      .len_code (cfg_q.wu_sel),
      .done     (warm_done)
   );

   stopwake_clkout u_out (
      .state_q     (state_q),
      .cfg_q       (cfg_q),
      .hi_osc_tick (hi_osc_tick),
      .lo_osc_tick (lo_osc_tick),
      .src_tick    (src_tick),
      .sys_clk_en  (sys_clk_en),
      .sys_clk_src (sys_clk_src),
      .osc_hi_on   (osc_hi_on),
      .osc_lo_on   (osc_lo_on)
   );

endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk
   import stopwake_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      halt_req,
   input logic      sys_clk_en,
   input logic      osc_hi_on,
   input logic      osc_lo_on,
   input logic      resume_pulse,
   input pstate_e   state_q,
   input wake_cfg_t cfg_q
);

   p_halt_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clk_en && halt_req |=> !sys_clk_en && !osc_hi_on && !osc_lo_on);

   p_stop_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PS_STOP |-> !sys_clk_en && !osc_hi_on && !osc_lo_on);

   p_warm_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PS_WARM |-> !sys_clk_en && (osc_hi_on || osc_lo_on));

   p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != PS_RUN |=> $stable(cfg_q));

   p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clk_en && !halt_req |=> sys_clk_en);

   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |=> !resume_pulse);

   p_pulse_at_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |-> sys_clk_en && !$past(sys_clk_en));

   p_rise_has_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_clk_en) |-> resume_pulse);

endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .halt_req     (halt_req),
   .sys_clk_en   (sys_clk_en),
   .osc_hi_on    (osc_hi_on),
   .osc_lo_on    (osc_lo_on),
   .resume_pulse (resume_pulse),
   .state_q      (state_q),
   .cfg_q        (cfg_q)
);

// File: tb/stopwake_ctrl_tb.sv
`timescale 1ns/1ps
module stopwake_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_wu_sel = 2'b00;
   logic       cfg_hi_en = 1'b0;
   logic       cfg_lo_en = 1'b0;
   logic       cfg_clk_sel = 1'b0;
   logic       halt_req = 1'b0;
   logic       wake_irq = 1'b0;
   logic       hi_osc_tick = 1'b0;
   logic       lo_osc_tick = 1'b0;
   logic       sys_clk_en;
   logic       sys_clk_src;
   logic       osc_hi_on;
   logic       osc_lo_on;
   logic       resume_pulse;

   int  checks = 0;
   int  fails = 0;
   bit  finished = 1'b0;
   bit  hi_gappy = 1'b0;
   logic [31:0] phase = '0;
   logic [1:0]  lo_div = '0;

   typedef struct {
      int n;
      bit src;
      bit hi;
      bit lo;
   } exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;

   stopwake_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wu_sel   (cfg_wu_sel),
      .cfg_hi_en    (cfg_hi_en),
      .cfg_lo_en    (cfg_lo_en),
      .cfg_clk_sel  (cfg_clk_sel),
      .halt_req     (halt_req),
      .wake_irq     (wake_irq),
      .hi_osc_tick  (hi_osc_tick),
      .lo_osc_tick  (lo_osc_tick),
      .sys_clk_en   (sys_clk_en),
      .sys_clk_src  (sys_clk_src),
      .osc_hi_on    (osc_hi_on),
      .osc_lo_on    (osc_lo_on),
      .resume_pulse (resume_pulse)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Oscillator model: ticks appear only while the enable is on, changed
   // one ns after the rising edge.
   always @(posedge clk) begin
      #1;
      phase  = phase + 1;
      lo_div = lo_div + 2'd1;
      hi_osc_tick = osc_hi_on && (!hi_gappy || phase[0]);
      lo_osc_tick = osc_lo_on && (lo_div == 2'd3);
   end

   // Monitor: counts source ticks during warm-up, compares at release.
   bit prev_en = 1'b1;
   bit pulse_follow = 1'b0;
   int tick_cnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         tick_cnt = 0;
         prev_en  = 1'b1;
      end else begin
         if (pulse_follow) begin
            chk(resume_pulse == 1'b0, "R10", "pulse width", resume_pulse, 0);
            pulse_follow = 1'b0;
         end
         if (sys_clk_en && !prev_en && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(tick_cnt == e.n, "R4", "warm-up ticks", tick_cnt, e.n);
            chk(sys_clk_src == e.src, "R6", "clock source", sys_clk_src, e.src);
            chk(osc_hi_on == e.hi, "R6", "fast osc enable", osc_hi_on, e.hi);
            chk(osc_lo_on == e.lo, "R6", "slow osc enable", osc_lo_on, e.lo);
            chk(resume_pulse == 1'b1, "R10", "pulse at release", resume_pulse, 1);
            tick_cnt = 0;
            pulse_follow = 1'b1;
         end else begin
            if (resume_pulse)
               chk(1'b0, "R10", "stray pulse", resume_pulse, 0);
            if (!sys_clk_en && (osc_hi_on || osc_lo_on) && expq.size() > 0)
               if (expq[0].src ? lo_osc_tick : hi_osc_tick)
                  tick_cnt++;
         end
         prev_en = sys_clk_en;
      end
   end

   task automatic write_cfg(input logic [1:0] code, input bit he, input bit le,
                            input bit sel);
      @(negedge clk);
      cfg_wu_sel = code; cfg_hi_en = he; cfg_lo_en = le; cfg_clk_sel = sel;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_case(input logic [1:0] code, input bit he, input bit le,
                           input bit sel, input bit gappy, input bit dbl_wake);
      exp_t e;
      hi_gappy = gappy;
      write_cfg(code, he, le, sel);
      e.n   = (code == 2'b10) ? 16384 : (code == 2'b11) ? 65536 : 256;
      e.src = sel;
      e.hi  = he | !sel;
      e.lo  = le | sel;
      expq.push_back(e);
      halt_req = 1'b1;
      @(negedge clk);
      halt_req = 1'b0;
      chk(!sys_clk_en && !osc_hi_on && !osc_lo_on, "R2", "gated after halt",
          {sys_clk_en, osc_hi_on, osc_lo_on}, 0);
      repeat (10) @(negedge clk);
      chk(!sys_clk_en && !osc_hi_on && !osc_lo_on, "R3", "dark while stopped",
          {sys_clk_en, osc_hi_on, osc_lo_on}, 0);
      // R7: conflicting write while stopped must be dropped
      write_cfg(~code, !he, !le, !sel);
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
      chk(sys_clk_en == 1'b0, "R5", "gated in warm-up", sys_clk_en, 0);
      chk(osc_hi_on == e.hi && osc_lo_on == e.lo, "R5", "osc enables in warm-up",
          {osc_hi_on, osc_lo_on}, {e.hi, e.lo});
      if (dbl_wake) begin
         repeat (5) @(negedge clk);
         wake_irq = 1'b1;          // R9: must not restart the count
         @(negedge clk);
         wake_irq = 1'b0;
      end
      while (expq.size() > 0) @(negedge clk);
      @(negedge clk);
      chk(sys_clk_en == 1'b1, "R4", "clock stays on after release", sys_clk_en, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sys_clk_en == 1'b1 && sys_clk_src == 1'b0, "R1", "reset clock",
          {sys_clk_en, sys_clk_src}, 2);
      chk(osc_hi_on == 1'b1 && osc_lo_on == 1'b0 && resume_pulse == 1'b0, "R1",
          "reset osc and pulse", {osc_hi_on, osc_lo_on, resume_pulse}, 4);

      // R8: wake-up while running
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(sys_clk_en == 1'b1 && resume_pulse == 1'b0, "R8", "wake in run",
             {sys_clk_en, resume_pulse}, 2);
      end

      run_case(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // reserved code, R4
      run_case(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);  // slow source, R6 R9
      run_case(2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);  // gapped fast ticks
      run_case(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);  // longest, source forced on

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule